// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Strobes

This block is a watchdog that counts ticks of a divided clock and raises a one-cycle reset request when software fails to service it in time. A free-running prescaler divides the system clock by `2**DIV_LOG2`. Each prescaler tick advances a timeout counter. The timeout length is `2**(BASE_LOG2 + sel)` ticks, and a 2-bit static selector picks `sel`. A static enable holds both the prescaler and the counter at zero while the watchdog is off.

Software services the watchdog through two distinct clear strobes. A static mode input chooses the servicing rule:

- **Single-strobe mode:** either strobe on its own restarts the count.
- **Paired mode:** both strobes must be seen, one after the other in either order, before the count restarts. Repeating the same strobe has no effect.

The block also keeps two status flags:

- **Timeout flag:** set when the watchdog expires.
- **Power-down flag:** set by a halt strobe.

An effective clear drops both flags. A halt strobe restarts the count, sets the power-down flag and drops the timeout flag.

Top module: `dual_clear_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `to_flag_o`, `pdf_flag_o` and `wdt_rst_o` are all 0.
- R2: With the watchdog enabled and no effective clear or halt, `wdt_rst_o` is high for exactly one cycle, `2**(BASE_LOG2+sel) * 2**DIV_LOG2` clock edges after the last restart. The count then begins again from zero.
- R3: `sel_cfg_i` value 0, 1, 2 or 3 selects a timeout of `2**BASE_LOG2`, `2**(BASE_LOG2+1)`, `2**(BASE_LOG2+2)` or `2**(BASE_LOG2+3)` prescaler ticks.
- R4: `to_flag_o` is set on the same edge that raises `wdt_rst_o`. It stays set until an effective clear or a halt.
- R5: With `dual_cfg_i` = 0, a pulse on `clr1_i` or on `clr2_i` is an effective clear. An effective clear restarts the prescaler and the counter, and drops `to_flag_o` and `pdf_flag_o`.
- R6: With `dual_cfg_i` = 1, a clear is effective only when one strobe follows an earlier pulse of the other strobe, in either order. A cycle with both strobes high also counts as a complete pair.
- R7: With `dual_cfg_i` = 1, repeating the same strobe without the other in between neither restarts the count nor changes either flag.
- R8: The pairing tracker forgets any pending strobe after an effective clear, a halt or a timeout. The next clear then needs both strobes again.
- R9: `halt_i` restarts the prescaler and the counter, sets `pdf_flag_o` and drops `to_flag_o`. A halt takes priority over a clear in the same cycle.
- R10: With `en_cfg_i` = 0, the count is held at zero and `wdt_rst_o` stays low. The strobes still update the flags and the tracker.
- R11: An effective clear on the edge where the timeout would expire wins: no reset pulse is issued and `to_flag_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cfg_i | input | 1 | Static watchdog enable |
| dual_cfg_i | input | 1 | Static servicing rule: 1 = paired strobes, 0 = single strobe |
| sel_cfg_i | input | 2 | Static timeout length select |
| clr1_i | input | 1 | First clear strobe, one cycle |
| clr2_i | input | 1 | Second clear strobe, one cycle |
| halt_i | input | 1 | Halt strobe, one cycle |
| to_flag_o | output | 1 | Timeout flag |
| pdf_flag_o | output | 1 | Power-down flag |
| wdt_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
Some rules are checked by assertions on every cycle:

- the reset request lasts a single cycle;
- the timeout flag rises only together with the reset request;
- the power-down flag rises only after a halt;
- a halt or a single-mode strobe leaves the flags in their cleared or power-down state on the next edge;
- a disabled watchdog never issues a reset.

Other behaviour depends on history and can only be shown by the bench scenarios, which compare the ports against a cycle model each cycle:

- the exact timeout length for each select value;
- whether a repeated strobe was ignored;
- whether a pending strobe was forgotten after a clear, halt or timeout;
- whether a clear arriving on the expiry edge beats the timeout.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [1:0] {
        PAIR_IDLE  = 2'd0,
        PAIR_HAVE1 = 2'd1,
        PAIR_HAVE2 = 2'd2
    } pair_state_e;

    typedef struct packed {
        logic to;
        logic pdf;
        logic rst_pulse;
    } wdt_flags_t;

    function automatic int unsigned period_log2(input int unsigned base, input logic [1:0] sel);
        return base + int'(sel);
    endfunction

endpackage

// File: rtl/dcw_prescale.sv
module dcw_prescale #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            assign tick_o = run_i && !restart_i;
        end else begin : g_div
            logic [DIV_LOG2-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || restart_i || !run_i) pre_q <= '0;
                else                            pre_q <= pre_q + 1'b1;
            end
            assign tick_o = run_i && !restart_i && (&pre_q);
        end
    endgenerate
endmodule

// File: rtl/dcw_counter.sv
module dcw_counter
    import dcw_pkg::*;
#(
    parameter int BASE_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    localparam int CW = BASE_LOG2 + 3;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    always_comb begin
        last_v = (CW'(1) << period_log2(BASE_LOG2, sel_i)) - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) cnt_q <= '0;
        else if (tick_i)                cnt_q <= (cnt_q == last_v) ? '0 : cnt_q + 1'b1;
    end

    assign expire_o = tick_i && (cnt_q == last_v);
endmodule

// File: rtl/dcw_clr_pair.sv
module dcw_clr_pair
    import dcw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dual_i,
    input  logic clr1_i,
    input  logic clr2_i,
    input  logic flush_i,
    output logic eff_o
);
    pair_state_e st_q, st_d;

    always_comb begin
        if (!dual_i) eff_o = clr1_i || clr2_i;
        else         eff_o = (clr1_i && clr2_i)
                           || (clr1_i && st_q == PAIR_HAVE2)
                           || (clr2_i && st_q == PAIR_HAVE1);
    end

    always_comb begin
        if (flush_i || eff_o) st_d = PAIR_IDLE;
        else if (clr1_i)      st_d = PAIR_HAVE1;
        else if (clr2_i)      st_d = PAIR_HAVE2;
        else                  st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PAIR_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dual_clear_watchdog.sv
module dual_clear_watchdog
    import dcw_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int DIV_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_cfg_i,
    input  logic       dual_cfg_i,
    input  logic [1:0] sel_cfg_i,
    input  logic       clr1_i,
    input  logic       clr2_i,
    input  logic       halt_i,
    output logic       to_flag_o,
    output logic       pdf_flag_o,
    output logic       wdt_rst_o
);
    logic       pair_eff;
    logic       clear_eff;
    logic       restart;
    logic       tick;
    logic       expire;
    wdt_flags_t flags_q;

    assign clear_eff = pair_eff && !halt_i;
    assign restart   = halt_i || clear_eff;

    dcw_clr_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .dual_i  (dual_cfg_i),
        .clr1_i  (clr1_i),
        .clr2_i  (clr2_i),
        .flush_i (halt_i || expire),
        .eff_o   (pair_eff)
    );

    dcw_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run_i     (en_cfg_i),
        .restart_i (restart),
        .tick_o    (tick)
    );

    dcw_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_i     (en_cfg_i),
        .restart_i (restart),
        .tick_i    (tick),
        .sel_i     (sel_cfg_i),
        .expire_o  (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.rst_pulse <= expire;
            if (halt_i) begin
                flags_q.pdf <= 1'b1;
                flags_q.to  <= 1'b0;
            end else if (clear_eff) begin
                flags_q.pdf <= 1'b0;
                flags_q.to  <= 1'b0;
            end else if (expire) begin
                flags_q.to  <= 1'b1;
            end
        end
    end

    assign to_flag_o  = flags_q.to;
    assign pdf_flag_o = flags_q.pdf;
    assign wdt_rst_o  = flags_q.rst_pulse;
endmodule

// File: rtl/dual_clear_watchdog_chk.sv
module dual_clear_watchdog_chk (
    input logic clk,
    input logic rst,
    input logic en_cfg_i,
    input logic dual_cfg_i,
    input logic clr1_i,
    input logic clr2_i,
    input logic halt_i,
    input logic to_flag_o,
    input logic pdf_flag_o,
    input logic wdt_rst_o
);
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> !wdt_rst_o);

    assert_to_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> to_flag_o);

    assert_to_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag_o) |-> wdt_rst_o);

    assert_single_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!dual_cfg_i && (clr1_i || clr2_i) && !halt_i) |=> (!to_flag_o && !pdf_flag_o && !wdt_rst_o));

    assert_same_cycle_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (dual_cfg_i && clr1_i && clr2_i && !halt_i) |=> (!to_flag_o && !pdf_flag_o));

    assert_halt_flags_R9: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (pdf_flag_o && !to_flag_o && !wdt_rst_o));

    assert_pdf_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pdf_flag_o) |-> $past(halt_i));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !en_cfg_i |=> !wdt_rst_o);
endmodule

bind dual_clear_watchdog dual_clear_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_cfg_i   (en_cfg_i),
    .dual_cfg_i (dual_cfg_i),
    .clr1_i     (clr1_i),
    .clr2_i     (clr2_i),
    .halt_i     (halt_i),
    .to_flag_o  (to_flag_o),
    .pdf_flag_o (pdf_flag_o),
    .wdt_rst_o  (wdt_rst_o)
);

// File: tb/dual_clear_watchdog_bench.sv
module dual_clear_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_LOG2  = 4;
    localparam int DIV_LOG2   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       dual = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       c1 = 1'b0;
    logic       c2 = 1'b0;
    logic       hl = 1'b0;
    logic       to_o, pdf_o, rst_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    int  m_cnt  = 0;
    int  m_pair = 0;
    bit  m_to   = 0;
    bit  m_pdf  = 0;
    bit  m_rst  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_clear_watchdog #(.BASE_LOG2(BASE_LOG2), .DIV_LOG2(DIV_LOG2)) u_dual_clear_watchdog (
        .clk(clk), .rst(rst), .en_cfg_i(en), .dual_cfg_i(dual), .sel_cfg_i(sel),
        .clr1_i(c1), .clr2_i(c2), .halt_i(hl),
        .to_flag_o(to_o), .pdf_flag_o(pdf_o), .wdt_rst_o(rst_o)
    );

    function automatic int n_cycles(input logic [1:0] s);
        return (1 << (BASE_LOG2 + int'(s))) << DIV_LOG2;
    endfunction

    function automatic bit eff_fn(input bit d, input bit a, input bit b, input int p);
        if (!d) return a || b;
        return (a && b) || (a && p == 2) || (b && p == 1);
    endfunction

    task automatic model_edge();
        bit hit;
        bit e;
        hit = 0;
        if (rst) begin
            m_cnt = 0; m_pair = 0; m_to = 0; m_pdf = 0; m_rst = 0;
        end else begin
            e = eff_fn(dual, c1, c2, m_pair);
            if (hl) begin
                m_pdf = 1; m_to = 0; m_cnt = 0; m_pair = 0; m_rst = 0;
            end else if (e) begin
                m_pdf = 0; m_to = 0; m_cnt = 0; m_pair = 0; m_rst = 0;
            end else begin
                if (!en) begin
                    m_cnt = 0; m_rst = 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == n_cycles(sel)) begin
                        m_rst = 1; m_to = 1; m_cnt = 0; hit = 1;
                    end else begin
                        m_rst = 0;
                    end
                end
                if (hit)     m_pair = 0;
                else if (c1) m_pair = 1;
                else if (c2) m_pair = 2;
            end
        end
    endtask

    task automatic check_outputs(input string tag);
        n_checks++;
        if (to_o !== m_to || pdf_o !== m_pdf || rst_o !== m_rst) begin
            n_fails++;
            $display("FAIL %s t=%0t actual to/pdf/rst=%b%b%b expected=%b%b%b",
                     tag, $time, to_o, pdf_o, rst_o, m_to, m_pdf, m_rst);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic pulse(input bit a, input bit b, input bit h, input string tag);
        c1 = a; c2 = b; hl = h;
        step(tag);
        c1 = 0; c2 = 0; hl = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        int r;
        void'($urandom(32'd20240611));
        // R1: reset state
        idle(3, "R1");
        rst = 0;
        step("R1");

        // R2 / R4: timeout in single mode, shortest period
        idle(n_cycles(0) + 6, "R2");
        // R3: every period select
        for (int s = 1; s < 4; s++) begin
            sel = 2'(s);
            pulse(1, 0, 0, "R3");
            idle(n_cycles(2'(s)) + 3, "R3");
        end
        sel = 2'd0;
        // R5: each strobe alone clears in single mode
        pulse(0, 1, 0, "R5");
        idle(n_cycles(0) - 5, "R5");
        pulse(1, 0, 0, "R5");
        idle(n_cycles(0) - 5, "R5");
        pulse(0, 1, 0, "R5");

        // R6: paired mode, both orders and same cycle
        dual = 1;
        pulse(1, 0, 0, "R6");
        idle(7, "R6");
        pulse(0, 1, 0, "R6");
        idle(n_cycles(0) - 3, "R6");
        pulse(0, 1, 0, "R6");
        idle(5, "R6");
        pulse(1, 0, 0, "R6");
        idle(20, "R6");
        pulse(1, 1, 0, "R6");
        idle(n_cycles(0) + 4, "R6");

        // R7: repeated first strobe never restarts the count
        pulse(1, 1, 0, "R7");
        for (int k = 0; k < 4; k++) begin
            idle(12, "R7");
            pulse(1, 0, 0, "R7");
        end
        idle(n_cycles(0), "R7");
        // R8: pending strobe forgotten after an effective clear
        pulse(1, 0, 0, "R8");
        pulse(0, 1, 0, "R8");
        pulse(0, 1, 0, "R8");
        idle(n_cycles(0) + 2, "R8");
        // R8: pending strobe forgotten after halt
        pulse(1, 0, 0, "R8");
        pulse(0, 0, 1, "R8");
        pulse(0, 1, 0, "R8");
        idle(10, "R8");

        // R9: halt alone and halt with a completing strobe
        pulse(1, 1, 1, "R9");
        idle(n_cycles(0) + 2, "R9");
        pulse(0, 0, 1, "R9");
        idle(4, "R9");

        // R11: effective clear on the expiry edge
        dual = 0;
        pulse(1, 0, 0, "R11");
        idle(n_cycles(0) - 1, "R11");
        pulse(0, 1, 0, "R11");
        idle(6, "R11");

        // R10: disabled watchdog
        en = 0;
        idle(n_cycles(0) * 3, "R10");
        pulse(0, 0, 1, "R10");
        pulse(1, 0, 0, "R10");
        idle(10, "R10");
        en = 1;
        idle(n_cycles(0) + 2, "R10");

        // Random mix across all rules (R2..R11)
        for (int i = 0; i < 5000; i++) begin
            r = int'($urandom % 100);
            if (r < 2)       pulse(1, 0, 0, "R6");
            else if (r < 4)  pulse(0, 1, 0, "R7");
            else if (r == 4) pulse(1, 1, 0, "R5");
            else if (r == 5) begin
                sel = 2'($urandom % 2);
                pulse(0, 0, 1, "R9");
            end else if (r == 6) begin
                dual = ~dual;
                step("R8");
            end else if (r == 7 && ($urandom % 8) == 0) begin
                en = ~en;
                step("R10");
            end else begin
                step("R2");
            end
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule